// File: doc/BRIEF.md
# Programmable Counter/Timer with Square-Wave Output

This block is a 16-bit down counter that advances on clock-enable pulses from one of several sources. A 3-bit mode code picks both the operating style and the source. In counter style it behaves as a one-shot interval counter. Once started it counts down the preload, raises a ready flag at terminal count and then halts. In timer style it runs freely. It reloads from the preload each time the count expires and toggles a square-wave output on each reload, so a full wave period lasts twice the preload in selected ticks.

Software loads the preload one byte at a time through two write strobes that share a byte bus. It then issues single-cycle start and stop commands and watches the ready flag. The block has two divide-by-16 prescalers: one on the external pulse input and one on the system clock. The transmit-rate pulses of two serial channels and the external pulse itself come from outside.

Top module: `sqct_timer`

## Requirements
- R1: While reset is asserted and after it is released, readyOut is 0 and squareOut is 1. The counter is idle until a start command, so no tick has any effect before then.
- R2: modeSel codes 0–3 select counter style and 4–7 select timer style. The tick source for each code is: 0 the external pulse; 1 channel-A transmit pulse; 2 channel-B transmit pulse; 3 system clock divided by 16; 4 the external pulse; 5 the external pulse divided by 16; 6 every system clock; 7 system clock divided by 16. Pulses on unselected sources are ignored.
- R3: A cycle with wrUpper high stores wrData into preload bits 15:8. A cycle with wrLower high stores wrData into bits 7:0. Each write leaves the other byte unchanged.
- R4: A preload of 0 or 1 is treated as 2.
- R5: A start command loads the preload into the counter, begins counting and sets squareOut to 1. A tick in the same cycle as a start is not counted.
- R6: In timer style, squareOut toggles on the Nth selected tick after a start or reload, where N is the effective preload. The counter then reloads, giving a period of 2N ticks.
- R7: In timer style, readyOut is set only when squareOut returns from 0 to 1. This happens once per full period, on every other expiry.
- R8: In timer style, a stop command clears readyOut on the next clock, and the timer keeps counting and toggling.
- R9: In counter style, readyOut is set on the Nth selected tick after a start and counting then halts. squareOut does not change in counter style.
- R10: In counter style, a stop command clears readyOut and halts counting. Later ticks do not set readyOut again until the next start.
- R11: Each divide-by-16 source pulses once for every 16 of its input events. The system-clock prescaler fires on the 16th, 32nd, … clock edge after reset is released.
- R12: If a stop command and a ready-setting expiry fall in the same cycle, the stop wins and readyOut ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Style and tick-source code |
| wrUpper | input | 1 | Store wrData into the preload upper byte |
| wrLower | input | 1 | Store wrData into the preload lower byte |
| wrData | input | 8 | Preload byte value |
| startCmd | input | 1 | Start command, one cycle |
| stopCmd | input | 1 | Stop command, one cycle |
| tickExt | input | 1 | External pulse enable |
| tickTxA | input | 1 | Channel-A transmit-rate pulse |
| tickTxB | input | 1 | Channel-B transmit-rate pulse |
| squareOut | output | 1 | Square-wave output |
| readyOut | output | 1 | Ready status flag |

## Verification
The bench targets the half-period edge: a counter that expires one tick early or late shifts every toggle and every ready pulse against the model. In timer style it checks that ready appears only on the rising half. A design that flagged every expiry would raise ready twice per period. Stop is exercised in both styles. A design that halted the timer on stop would stop the wave, and one that let an expiry beat a simultaneous stop would leave ready set. Preloads of zero and 0x0100 test the clamp and the byte placement. Start-with-tick and the divide-by-16 sources catch off-by-one prescaler phases and ticks counted during a load.

// File: rtl/sqct_pkg.sv
package sqct_pkg;

  // Strobes from control to datapath, plus the state-update intents.
  typedef struct packed {
    logic load;
    logic decr;
    logic toggle;
    logic setReady;
    logic clrReady;
  } ctStrobe_t;

  typedef enum logic [2:0] {
    SRC_C_EXT   = 3'd0,
    SRC_C_TXA   = 3'd1,
    SRC_C_TXB   = 3'd2,
    SRC_C_SYS16 = 3'd3,
    SRC_T_EXT   = 3'd4,
    SRC_T_EXT16 = 3'd5,
    SRC_T_SYS   = 3'd6,
    SRC_T_SYS16 = 3'd7
  } ctMode_e;

endpackage

// File: rtl/sqct_prescale.sv
module sqct_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic evIn,
  output logic evOut
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign evOut = evIn && (phase == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (evIn) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/sqct_tick_sel.sv
module sqct_tick_sel
  import sqct_pkg::*;
#(
  parameter int PRESCALE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       tickExt,
  input  logic       tickTxA,
  input  logic       tickTxB,
  output logic       selTick
);
  logic extDiv;
  logic sysDiv;

  sqct_prescale #(.DIV(PRESCALE)) extPre_i (
    .clk   (clk),
    .rstN  (rstN),
    .evIn  (tickExt),
    .evOut (extDiv)
  );

  sqct_prescale #(.DIV(PRESCALE)) sysPre_i (
    .clk   (clk),
    .rstN  (rstN),
    .evIn  (1'b1),
    .evOut (sysDiv)
  );

  always_comb begin
    unique case (ctMode_e'(modeSel))
      SRC_C_EXT:   selTick = tickExt;
      SRC_C_TXA:   selTick = tickTxA;
      SRC_C_TXB:   selTick = tickTxB;
      SRC_C_SYS16: selTick = sysDiv;
      SRC_T_EXT:   selTick = tickExt;
      SRC_T_EXT16: selTick = extDiv;
      SRC_T_SYS:   selTick = 1'b1;
      SRC_T_SYS16: selTick = sysDiv;
      default:     selTick = 1'b0;
    endcase
  end
endmodule

// File: rtl/sqct_datapath.sv
module sqct_datapath
  import sqct_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int MIN_LOAD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrUpper,
  input  logic              wrLower,
  input  logic [BYTE_W-1:0] wrData,
  input  ctStrobe_t         strb,
  output logic              atTerminal
);
  localparam int UP_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_LOAD);

  logic [UP_W-1:0]   upperReg;
  logic [BYTE_W-1:0] lowerReg;
  logic [CNT_W-1:0]  preload;
  logic [CNT_W-1:0]  loadVal;
  logic [CNT_W-1:0]  count;

  assign preload    = {upperReg, lowerReg};
  assign loadVal    = (preload < MIN_VAL) ? MIN_VAL : preload;
  assign atTerminal = (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperReg <= '0;
      lowerReg <= '0;
    end else begin
      if (wrUpper) upperReg <= UP_W'(wrData);
      if (wrLower) lowerReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.load) begin
      count <= loadVal;
    end else if (strb.decr) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/sqct_ctrl.sv
module sqct_ctrl
  import sqct_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      timerMode,
  input  logic      selTick,
  input  logic      startCmd,
  input  logic      stopCmd,
  input  logic      atTerminal,
  output ctStrobe_t strb,
  output logic      squareOut,
  output logic      readyOut
);
  logic running;
  logic countEv;
  logic expire;
  logic haltNow;

  assign countEv = running && selTick && !startCmd;
  assign expire  = countEv && atTerminal;
  assign haltNow = !timerMode && (expire || stopCmd);

  always_comb begin
    strb          = '0;
    strb.load     = startCmd || (expire && timerMode);
    strb.decr     = countEv && !atTerminal;
    strb.toggle   = expire && timerMode;
    strb.setReady = expire && (!timerMode || !squareOut);
    strb.clrReady = stopCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      squareOut <= 1'b1;
      readyOut  <= 1'b0;
    end else begin
      if (startCmd)     running <= 1'b1;
      else if (haltNow) running <= 1'b0;

      if (startCmd)         squareOut <= 1'b1;
      else if (strb.toggle) squareOut <= !squareOut;

      if (strb.clrReady)      readyOut <= 1'b0;
      else if (strb.setReady) readyOut <= 1'b1;
    end
  end
endmodule

// File: rtl/sqct_timer.sv
module sqct_timer
  import sqct_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int MIN_LOAD = 2,
  parameter int PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              wrUpper,
  input  logic              wrLower,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              startCmd,
  input  logic              stopCmd,
  input  logic              tickExt,
  input  logic              tickTxA,
  input  logic              tickTxB,
  output logic              squareOut,
  output logic              readyOut
);
  ctStrobe_t strb;
  logic      selTick;
  logic      atTerminal;

  sqct_tick_sel #(.PRESCALE(PRESCALE)) tickSel_i (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .tickExt (tickExt),
    .tickTxA (tickTxA),
    .tickTxB (tickTxB),
    .selTick (selTick)
  );

  sqct_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .timerMode  (modeSel[2]),
    .selTick    (selTick),
    .startCmd   (startCmd),
    .stopCmd    (stopCmd),
    .atTerminal (atTerminal),
    .strb       (strb),
    .squareOut  (squareOut),
    .readyOut   (readyOut)
  );

  sqct_datapath #(
    .CNT_W    (CNT_W),
    .BYTE_W   (BYTE_W),
    .MIN_LOAD (MIN_LOAD)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrUpper    (wrUpper),
    .wrLower    (wrLower),
    .wrData     (wrData),
    .strb       (strb),
    .atTerminal (atTerminal)
  );
endmodule

// File: rtl/sqct_checker.sv
module sqct_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] modeSel,
  input logic       startCmd,
  input logic       stopCmd,
  input logic       selTick,
  input logic       squareOut,
  input logic       readyOut
);
  // R5: a start always leaves the wave high
  p_start_sets_square_r5: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> squareOut);

  // R8 / R12: a stop always leaves ready low
  p_stop_clears_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> !readyOut);

  // R9: counter style never moves the wave except through a start
  p_counter_square_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[2] && !startCmd) |=> $stable(squareOut));

  // R6: without a selected tick the wave holds
  p_square_needs_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!selTick && !startCmd) |=> $stable(squareOut));

  // R7: in timer style ready only rises together with a rising wave
  p_ready_on_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[2] && !readyOut) |=> (!readyOut || (squareOut && !$past(squareOut))));
endmodule

bind sqct_timer sqct_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .startCmd  (startCmd),
  .stopCmd   (stopCmd),
  .selTick   (selTick),
  .squareOut (squareOut),
  .readyOut  (readyOut)
);

// File: tb/sqct_timer_tb.sv
`timescale 1ns/1ps
module sqct_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic       wrUpper = 1'b0;
  logic       wrLower = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       startCmd = 1'b0;
  logic       stopCmd = 1'b0;
  logic       tickExt = 1'b0;
  logic       tickTxA = 1'b0;
  logic       tickTxB = 1'b0;
  logic       squareOut;
  logic       readyOut;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  always #2 clk = ~clk;

  sqct_timer dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .wrUpper   (wrUpper),
    .wrLower   (wrLower),
    .wrData    (wrData),
    .startCmd  (startCmd),
    .stopCmd   (stopCmd),
    .tickExt   (tickExt),
    .tickTxA   (tickTxA),
    .tickTxB   (tickTxB),
    .squareOut (squareOut),
    .readyOut  (readyOut)
  );

  // Behavioural reference model
  int mUp, mLo, mCount, mExt, mSys;
  bit mRun, mSq, mRdy;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mUp = 0; mLo = 0; mCount = 0; mExt = 0; mSys = 0;
      mRun = 0; mSq = 1; mRdy = 0;
    end else begin
      bit tk, isT, ev, expire, rdySet;
      int ld;
      case (modeSel)
        3'd0, 3'd4: tk = tickExt;
        3'd1:       tk = tickTxA;
        3'd2:       tk = tickTxB;
        3'd5:       tk = tickExt && (mExt == 15);
        3'd6:       tk = 1'b1;
        default:    tk = (mSys == 15);
      endcase
      isT = modeSel[2];
      ld = mUp * 256 + mLo;
      if (ld < 2) ld = 2;
      ev = mRun && tk && !startCmd;
      expire = ev && (mCount == 1);
      rdySet = expire && (!isT || !mSq);
      if (startCmd) begin
        mCount = ld; mRun = 1; mSq = 1;
      end else if (expire) begin
        if (isT) begin
          mCount = ld; mSq = !mSq;
        end else begin
          mRun = 0;
        end
      end else if (ev) begin
        mCount = mCount - 1;
      end
      if (!startCmd && !isT && stopCmd) mRun = 0;
      if (stopCmd) mRdy = 0;
      else if (rdySet) mRdy = 1;
      if (wrUpper) mUp = wrData;
      if (wrLower) mLo = wrData;
      mSys = (mSys + 1) % 16;
      if (tickExt) mExt = (mExt + 1) % 16;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (squareOut !== mSq || readyOut !== mRdy) begin
        errors++;
        $display("FAIL %s model compare: square=%0b ready=%0b expected square=%0b ready=%0b",
                 curReq, squareOut, readyOut, mSq, mRdy);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrPre(input logic [15:0] v);
    wrUpper = 1'b1; wrData = v[15:8];
    @(negedge clk);
    wrUpper = 1'b0; wrLower = 1'b1; wrData = v[7:0];
    @(negedge clk);
    wrLower = 1'b0;
  endtask

  task automatic pulseStart();
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
  endtask

  task automatic pulseStop();
    stopCmd = 1'b1;
    @(negedge clk);
    stopCmd = 1'b0;
  endtask

  task automatic halt();
    modeSel = 3'd1;
    pulseStop();
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      finishRun();
    end
  end

  initial begin
    int toggles;
    logic prevSq;

    // R1 reset state
    cyc(3);
    chk("R1 ready in reset", readyOut, 1'b0);
    chk("R1 square in reset", squareOut, 1'b1);
    rstN = 1'b1;
    tickTxA = 1'b1;
    cyc(5);
    tickTxA = 1'b0;
    chk("R1 idle after reset", readyOut, 1'b0);

    // R5 R6 R7 timer style on system clock, preload 3
    curReq = "R6";
    modeSel = 3'd6;
    wrPre(16'h0003);
    pulseStart();
    chk("R5 square high after start", squareOut, 1'b1);
    cyc(2);
    chk("R6 square still high after 2 ticks", squareOut, 1'b1);
    cyc(1);
    chk("R6 square low after 3 ticks", squareOut, 1'b0);
    chk("R7 no ready on falling half", readyOut, 1'b0);
    cyc(2);
    chk("R7 ready still low before period end", readyOut, 1'b0);
    cyc(1);
    chk("R6 square high after 6 ticks", squareOut, 1'b1);
    chk("R7 ready at end of period", readyOut, 1'b1);
    curReq = "R7";
    cyc(20);

    // R8 stop in timer style
    curReq = "R8";
    pulseStop();
    chk("R8 ready cleared by stop", readyOut, 1'b0);
    toggles = 0;
    prevSq = squareOut;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (squareOut !== prevSq) toggles++;
      prevSq = squareOut;
    end
    chk("R8 timer keeps running after stop", toggles >= 3, 1'b1);

    // R4 clamp
    curReq = "R4";
    wrPre(16'h0000);
    pulseStart();
    cyc(1);
    chk("R4 square high after 1 tick", squareOut, 1'b1);
    cyc(1);
    chk("R4 square low after 2 ticks", squareOut, 1'b0);
    cyc(10);

    // R9 R10 R11 counter on system clock / 16
    curReq = "R11";
    halt();
    modeSel = 3'd3;
    wrPre(16'h0002);
    pulseStart();
    cyc(40);
    chk("R11 R9 counter ready after two divided ticks", readyOut, 1'b1);
    chk("R9 square unchanged in counter style", squareOut, 1'b1);
    curReq = "R10";
    pulseStop();
    chk("R10 stop clears ready", readyOut, 1'b0);
    cyc(40);
    chk("R10 halted counter stays idle", readyOut, 1'b0);

    // R3 R2 upper byte via channel-A ticks
    curReq = "R3";
    halt();
    modeSel = 3'd1;
    wrPre(16'h0100);
    pulseStart();
    tickTxA = 1'b1;
    cyc(255);
    chk("R3 no ready after 255 ticks of 0x0100", readyOut, 1'b0);
    cyc(1);
    chk("R3 ready after 256 ticks", readyOut, 1'b1);
    tickTxA = 1'b0;
    cyc(3);

    // R2 channel-B source ignores channel-A pulses
    curReq = "R2";
    halt();
    modeSel = 3'd2;
    wrPre(16'h0002);
    pulseStart();
    tickTxA = 1'b1;
    cyc(10);
    tickTxA = 1'b0;
    chk("R2 unselected source ignored", readyOut, 1'b0);
    tickTxB = 1'b1;
    cyc(2);
    tickTxB = 1'b0;
    chk("R2 selected channel-B source counts", readyOut, 1'b1);
    cyc(2);

    // R12 stop coinciding with expiry
    curReq = "R12";
    halt();
    modeSel = 3'd1;
    wrPre(16'h0002);
    pulseStart();
    tickTxA = 1'b1;
    @(negedge clk);
    stopCmd = 1'b1;
    @(negedge clk);
    stopCmd = 1'b0;
    tickTxA = 1'b1;
    cyc(3);
    tickTxA = 1'b0;
    chk("R12 stop wins over expiry", readyOut, 1'b0);

    // R5 tick in the start cycle is not counted
    curReq = "R5";
    halt();
    modeSel = 3'd0;
    wrPre(16'h0002);
    tickExt = 1'b1;
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    @(negedge clk);
    chk("R5 start-cycle tick not counted", readyOut, 1'b0);
    @(negedge clk);
    tickExt = 1'b0;
    chk("R5 ready after two counted ticks", readyOut, 1'b1);

    // R11 external / 16 in timer style
    curReq = "R11";
    halt();
    modeSel = 3'd5;
    wrPre(16'h0002);
    pulseStart();
    toggles = 0;
    prevSq = squareOut;
    for (int i = 0; i < 160; i++) begin
      tickExt = (i % 2 == 0);
      @(negedge clk);
      if (squareOut !== prevSq) toggles++;
      prevSq = squareOut;
    end
    tickExt = 1'b0;
    chk("R11 divided external source toggles wave", (toggles >= 1) && (toggles <= 3), 1'b1);

    // R2 plain external source in timer style
    curReq = "R2";
    modeSel = 3'd4;
    pulseStart();
    for (int i = 0; i < 30; i++) begin
      tickExt = (i % 3 != 0);
      @(negedge clk);
    end
    tickExt = 1'b0;
    cyc(2);

    finishRun();
  end
endmodule